// File: doc/BRIEF.md
# Condition Status and Control Translator with Priority Interrupt Channels

This block stands between a processor's condition-out and condition-in I/O operations and a host-to-network interface that offers only its own native registers. The native control register cannot be read back, so the block keeps a shadow copy of it. The block also keeps a status word of its own. That word holds a sticky "node has been down" flop, the end-of-input, ready-for-output and input-ready flags, and a 3-bit priority interrupt channel for each of those three events. A condition-out word is decoded into updates of the shadows, a native control write, and the clear pulses and data writes the interface needs. A condition-in read returns a word built from the shadows and the live native status.

Native interface events arrive as a strobe with the native status word. Each event is turned into one-cycle requests on a bus of priority interrupt channels. Bits of the condition words are numbered from the most significant end: bit N of a 36-bit word is vector index 35-N. So bit 19 is `[16]`, bits 25..27 are `[10:8]`, bits 29..31 are `[6:4]` and bits 33..35 are `[2:0]`.

Top module: `cstat_bridge`

## Requirements
- R1: After reset, the control word `ctl_word` (`[3]` host ready, `[2]` last output word, `[1]` input interrupt enable, `[0]` output interrupt enable) is zero, `pi_req` and all pulse outputs are low, and the status word has only interface-powered (bit 19) and ready-for-output (bit 28) set.
- R2: `coni_word` shows the following, with all other bits zero: bit 19 powered, bit 20 node down now, bit 21 node has been down, bit 24 end of input with its channel in bits 25..27, bit 28 ready for output with its channel in bits 29..31, and bit 32 input ready with its channel in bits 33..35.
- R3: When `nat_status` is all ones, the interface counts as absent. `coni_word` is then zero, events are disregarded, and the down flop is not set.
- R4: Bit 20 of `coni_word` is native status bit 19 (node not ready), shown live. A condition-in read or an event that sees the node down sets the has-been-down flop. Bit 21 is that flop OR the live down signal. Condition-out bit 19 clears the flop.
- R5: Each condition-out raises `ctl_wr` for one cycle in the next cycle. Host ready becomes the inverse of condition-out bit 20. Bit 22 sets last-output-word and clears ready-for-output.
- R6: Condition-out bit 21 clears the output interrupt enable and pulses `clr_out` in the next cycle.
- R7: Condition-out bit 22, given while native bit 12 (output empty) is set, pulses `data_wr` in the next cycle with `data_word` zero.
- R8: Condition-out bit 23 pulses `clr_in` in the next cycle and `clr_in_full` in the cycle after that. It sets the input interrupt enable and clears the end-of-input and input-ready flags.
- R9: Condition-out bits 24, 28 and 32 each load the 3-bit field that follows them. A field whose load bit is clear keeps its value. A nonzero output channel sets the output enable. A nonzero input or end-of-input channel sets the input enable.
- R10: An event with native bit 14 (needs data) set while the output enable is on sets ready-for-output, clears the output enable, writes the control word, and requests the output channel.
- R11: An event with native bit 18 (input full) set sets input-ready. If the input enable is on and bit 16 is clear, it requests the input channel and clears the input enable.
- R12: An event with native bit 16 (last bit seen) set sets input-ready and end-of-input. If the input enable is on, it requests the input channel in the next cycle, keeps the enable on, and in the cycle after that requests the end-of-input channel and clears the enable.
- R13: A request on channel c is a one-cycle pulse on `pi_req[c-1]`. Channel 0 raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cono_valid | input | 1 | condition-out strobe |
| cono_word | input | 36 | condition-out word |
| coni_rd | input | 1 | condition-in read strobe |
| coni_word | output | 36 | condition-in word (combinational) |
| nat_status | input | 20 | native interface status |
| nat_event | input | 1 | native interface event strobe |
| ctl_wr | output | 1 | native control register write pulse |
| ctl_word | output | 4 | control shadow value |
| clr_out | output | 1 | clear-output pulse |
| clr_in | output | 1 | clear-input pulse |
| clr_in_full | output | 1 | clear-input-full pulse |
| data_wr | output | 1 | native data write pulse |
| data_word | output | 36 | native data word |
| pi_req | output | 7 | priority interrupt requests, one per channel |

## Verification
`coni_word` is combinational. It is checked a little after its inputs change, in the same cycle, and again after the edge that may set the down flop. Every condition-out result (shadow, `ctl_wr`, `clr_out`, `clr_in`, `data_wr`) is due one edge after the strobe, and `clr_in_full` one edge later. The bench drives at the falling edge and samples at the following falling edge, then one cycle later. An event's first request is due one edge after the strobe, and the end-of-input request of the paired case one edge after that. The bench checks both cycles and leaves a quiet cycle before the next stimulus.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

   // control shadow, packed so that [0] is the output enable
   typedef struct packed {
      logic host_rdy;
      logic last_w;
      logic in_ie;
      logic out_ie;
   } ctl_t;

   // state changes requested by the event sequencer
   typedef struct packed {
      logic set_rdy;
      logic clr_out_ie;
      logic set_inrdy;
      logic set_eoi;
      logic clr_in_ie;
   } ev_act_t;

endpackage

// File: rtl/cstat_cono_dec.sv
module cstat_cono_dec #(
   parameter int WORD_W = 36,
   parameter int CH_W   = 3
) (
   input  logic [WORD_W-1:0] word,
   output logic              c_clr_err,
   output logic              c_host_down,
   output logic              c_stop_out,
   output logic              c_end_out,
   output logic              c_clr_in,
   output logic              c_ld_eoi,
   output logic              c_ld_out,
   output logic              c_ld_in,
   output logic [CH_W-1:0]   f_eoi,
   output logic [CH_W-1:0]   f_out,
   output logic [CH_W-1:0]   f_in
);
   // bit n counted from the MSB sits at index WORD_W-1-n
   localparam int B_CLR_ERR = WORD_W - 1 - 19;
   localparam int B_HOST_DN = WORD_W - 1 - 20;
   localparam int B_STOP    = WORD_W - 1 - 21;
   localparam int B_END     = WORD_W - 1 - 22;
   localparam int B_CLR_IN  = WORD_W - 1 - 23;
   localparam int B_LD_EOI  = WORD_W - 1 - 24;
   localparam int B_LD_OUT  = WORD_W - 1 - 28;
   localparam int B_LD_IN   = WORD_W - 1 - 32;

   assign c_clr_err   = word[B_CLR_ERR];
   assign c_host_down = word[B_HOST_DN];
   assign c_stop_out  = word[B_STOP];
   assign c_end_out   = word[B_END];
   assign c_clr_in    = word[B_CLR_IN];
   assign c_ld_eoi    = word[B_LD_EOI];
   assign c_ld_out    = word[B_LD_OUT];
   assign c_ld_in     = word[B_LD_IN];
   assign f_eoi       = word[B_LD_EOI-1 -: CH_W];
   assign f_out       = word[B_LD_OUT-1 -: CH_W];
   assign f_in        = word[B_LD_IN-1 -: CH_W];

   logic unused_hi;
   assign unused_hi = ^word[WORD_W-1:B_CLR_ERR+1];
endmodule

// File: rtl/cstat_irq.sv
module cstat_irq
   import cstat_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev,
   input  logic            needs,
   input  logic            full,
   input  logic            last,
   input  ctl_t            ctl,
   input  logic [CH_W-1:0] ch_eoi,
   input  logic [CH_W-1:0] ch_out,
   input  logic [CH_W-1:0] ch_in,
   output ev_act_t         act,
   output logic [(1<<CH_W)-2:0] pi_req
);
   localparam int NUM_CH = (1 << CH_W) - 1;

   logic [NUM_CH-1:0] sel_eoi, sel_out, sel_in;
   logic [NUM_CH-1:0] pi_q;
   logic              pend_q;
   logic              fire_out, in_seen, fire_in;

   // channel c maps to line c-1; channel 0 selects nothing
   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
      assign sel_eoi[gi] = (ch_eoi == CH_W'(gi + 1));
      assign sel_out[gi] = (ch_out == CH_W'(gi + 1));
      assign sel_in[gi]  = (ch_in  == CH_W'(gi + 1));
   end

   assign fire_out = ev & needs & ctl.out_ie;
   assign in_seen  = ev & (full | last);
   assign fire_in  = in_seen & ctl.in_ie;

   always_comb begin
      act            = '0;
      act.set_rdy    = fire_out;
      act.clr_out_ie = fire_out;
      act.set_inrdy  = in_seen;
      act.set_eoi    = ev & last;
      act.clr_in_ie  = (fire_in & ~last) | pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pi_q   <= '0;
      end else begin
         pend_q <= fire_in & last;
         pi_q   <= ({NUM_CH{fire_out}} & sel_out)
                 | ({NUM_CH{fire_in}}  & sel_in)
                 | ({NUM_CH{pend_q}}   & sel_eoi);
      end
   end

   assign pi_req = pi_q;

   AST_PEND_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> $past(ev) && $past(last)); // R12
   AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|pi_q) |-> ($past(ev) || $past(pend_q))); // R13
   AST_PEND_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !ctl.in_ie); // R12
endmodule

// File: rtl/cstat_shadow.sv
module cstat_shadow
   import cstat_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cono_valid,
   input  logic            c_clr_err,
   input  logic            c_host_down,
   input  logic            c_stop_out,
   input  logic            c_end_out,
   input  logic            c_clr_in,
   input  logic            c_ld_eoi,
   input  logic            c_ld_out,
   input  logic            c_ld_in,
   input  logic [CH_W-1:0] f_eoi,
   input  logic [CH_W-1:0] f_out,
   input  logic [CH_W-1:0] f_in,
   input  logic            err_set,
   input  logic            out_empty,
   input  ev_act_t         act,
   output ctl_t            ctl,
   output logic            pwr,
   output logic            err,
   output logic            rdy,
   output logic            eoi,
   output logic            inrdy,
   output logic [CH_W-1:0] ch_eoi,
   output logic [CH_W-1:0] ch_out,
   output logic [CH_W-1:0] ch_in,
   output logic            ctl_wr,
   output logic            clr_out,
   output logic            clr_in,
   output logic            clr_in_full,
   output logic            data_wr
);
   ctl_t            ctl_q;
   logic            pwr_q, err_q, rdy_q, eoi_q, inrdy_q;
   logic [CH_W-1:0] ch_eoi_q, ch_out_q, ch_in_q;
   logic            ctl_wr_q, clr_out_q, clr_in_q, clr_full_q, data_wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         pwr_q      <= 1'b1;
         err_q      <= 1'b0;
         rdy_q      <= 1'b1;
         eoi_q      <= 1'b0;
         inrdy_q    <= 1'b0;
         ch_eoi_q   <= '0;
         ch_out_q   <= '0;
         ch_in_q    <= '0;
         ctl_wr_q   <= 1'b0;
         clr_out_q  <= 1'b0;
         clr_in_q   <= 1'b0;
         clr_full_q <= 1'b0;
         data_wr_q  <= 1'b0;
      end else begin
         ctl_wr_q   <= cono_valid | act.clr_out_ie | act.clr_in_ie;
         clr_out_q  <= cono_valid & c_stop_out;
         clr_in_q   <= cono_valid & c_clr_in;
         clr_full_q <= clr_in_q;
         data_wr_q  <= cono_valid & c_end_out & out_empty;

         // event side first, condition-out applied over it
         if (act.set_rdy)    rdy_q        <= 1'b1;
         if (act.clr_out_ie) ctl_q.out_ie <= 1'b0;
         if (act.set_inrdy)  inrdy_q      <= 1'b1;
         if (act.set_eoi)    eoi_q        <= 1'b1;
         if (act.clr_in_ie)  ctl_q.in_ie  <= 1'b0;

         if (cono_valid) begin
            ctl_q.host_rdy <= ~c_host_down;
            if (c_clr_err) err_q <= 1'b0;
            if (c_end_out) begin
               ctl_q.last_w <= 1'b1;
               rdy_q        <= 1'b0;
            end
            if (c_stop_out) ctl_q.out_ie <= 1'b0;
            if (c_clr_in) begin
               ctl_q.in_ie <= 1'b1;
               eoi_q       <= 1'b0;
               inrdy_q     <= 1'b0;
            end
            if (c_ld_eoi) begin
               ch_eoi_q <= f_eoi;
               if (f_eoi != '0) ctl_q.in_ie <= 1'b1;
            end
            if (c_ld_out) begin
               ch_out_q <= f_out;
               if (f_out != '0) ctl_q.out_ie <= 1'b1;
            end
            if (c_ld_in) begin
               ch_in_q <= f_in;
               if (f_in != '0) ctl_q.in_ie <= 1'b1;
            end
         end
         if (err_set) err_q <= 1'b1;
      end
   end

   assign ctl         = ctl_q;
   assign pwr         = pwr_q;
   assign err         = err_q;
   assign rdy         = rdy_q;
   assign eoi         = eoi_q;
   assign inrdy       = inrdy_q;
   assign ch_eoi      = ch_eoi_q;
   assign ch_out      = ch_out_q;
   assign ch_in       = ch_in_q;
   assign ctl_wr      = ctl_wr_q;
   assign clr_out     = clr_out_q;
   assign clr_in      = clr_in_q;
   assign clr_in_full = clr_full_q;
   assign data_wr     = data_wr_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_q); // R4
   AST_STOP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      cono_valid && c_stop_out && !(c_ld_out && f_out != '0) |=> !ctl_q.out_ie); // R6
   AST_CLR_IN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      cono_valid && c_clr_in |=> ctl_q.in_ie && !eoi_q && !inrdy_q); // R8
endmodule

// File: rtl/cstat_coni_fmt.sv
module cstat_coni_fmt #(
   parameter int WORD_W = 36,
   parameter int CH_W   = 3
) (
   input  logic              absent,
   input  logic              node_down,
   input  logic              pwr,
   input  logic              err,
   input  logic              eoi,
   input  logic [CH_W-1:0]   ch_eoi,
   input  logic              rdy,
   input  logic [CH_W-1:0]   ch_out,
   input  logic              inrdy,
   input  logic [CH_W-1:0]   ch_in,
   output logic [WORD_W-1:0] coni_word
);
   localparam int B_PWR  = WORD_W - 1 - 19;
   localparam int B_DOWN = WORD_W - 1 - 20;
   localparam int B_WAS  = WORD_W - 1 - 21;
   localparam int B_EOI  = WORD_W - 1 - 24;
   localparam int B_RDY  = WORD_W - 1 - 28;
   localparam int B_INR  = WORD_W - 1 - 32;

   always_comb begin
      coni_word = '0;
      if (!absent) begin
         coni_word[B_PWR]             = pwr;
         coni_word[B_DOWN]            = node_down;
         coni_word[B_WAS]             = err | node_down;
         coni_word[B_EOI]             = eoi;
         coni_word[B_EOI-1 -: CH_W]   = ch_eoi;
         coni_word[B_RDY]             = rdy;
         coni_word[B_RDY-1 -: CH_W]   = ch_out;
         coni_word[B_INR]             = inrdy;
         coni_word[B_INR-1 -: CH_W]   = ch_in;
      end
   end
endmodule

// File: rtl/cstat_bridge.sv
module cstat_bridge
   import cstat_pkg::*;
#(
   parameter int WORD_W  = 36,
   parameter int CH_W    = 3,
   parameter int NAT_W   = 20,
   parameter int P_EMPTY = 12,
   parameter int P_NEEDS = 14,
   parameter int P_LAST  = 16,
   parameter int P_FULL  = 18,
   parameter int P_DOWN  = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cono_valid,
   input  logic [WORD_W-1:0]    cono_word,
   input  logic                 coni_rd,
   output logic [WORD_W-1:0]    coni_word,
   input  logic [NAT_W-1:0]     nat_status,
   input  logic                 nat_event,
   output logic                 ctl_wr,
   output logic [3:0]           ctl_word,
   output logic                 clr_out,
   output logic                 clr_in,
   output logic                 clr_in_full,
   output logic                 data_wr,
   output logic [WORD_W-1:0]    data_word,
   output logic [(1<<CH_W)-2:0] pi_req
);
   localparam int NUM_CH = (1 << CH_W) - 1;

   // elaboration-time parameter checks
   if (CH_W != 3) begin : g_bad_ch
      $error("channel fields are three bits wide in this layout");
   end
   if (WORD_W < 36) begin : g_bad_word
      $error("condition words need at least 36 bits");
   end
   if (P_EMPTY >= NAT_W || P_NEEDS >= NAT_W || P_LAST >= NAT_W ||
       P_FULL >= NAT_W || P_DOWN >= NAT_W) begin : g_bad_pos
      $error("native status bit position outside the status width");
   end

   logic            absent, node_down, ev_ok, err_set;
   logic            c_clr_err, c_host_down, c_stop_out, c_end_out, c_clr_in;
   logic            c_ld_eoi, c_ld_out, c_ld_in;
   logic [CH_W-1:0] f_eoi, f_out, f_in;
   logic [CH_W-1:0] ch_eoi, ch_out, ch_in;
   logic            pwr, err, rdy, eoi, inrdy;
   ctl_t            ctl;
   ev_act_t         act;
   logic [NUM_CH-1:0] pi_int;

   assign absent    = &nat_status;
   assign node_down = nat_status[P_DOWN];
   assign ev_ok     = nat_event & ~absent;
   assign err_set   = (coni_rd | nat_event) & node_down & ~absent;

   cstat_cono_dec #(.WORD_W(WORD_W), .CH_W(CH_W)) i_dec (
      .word(cono_word), .c_clr_err(c_clr_err), .c_host_down(c_host_down),
      .c_stop_out(c_stop_out), .c_end_out(c_end_out), .c_clr_in(c_clr_in),
      .c_ld_eoi(c_ld_eoi), .c_ld_out(c_ld_out), .c_ld_in(c_ld_in),
      .f_eoi(f_eoi), .f_out(f_out), .f_in(f_in));

   cstat_irq #(.CH_W(CH_W)) i_irq (
      .clk(clk), .rst_n(rst_n), .ev(ev_ok),
      .needs(nat_status[P_NEEDS]), .full(nat_status[P_FULL]),
      .last(nat_status[P_LAST]), .ctl(ctl),
      .ch_eoi(ch_eoi), .ch_out(ch_out), .ch_in(ch_in),
      .act(act), .pi_req(pi_int));

   cstat_shadow #(.CH_W(CH_W)) i_shadow (
      .clk(clk), .rst_n(rst_n), .cono_valid(cono_valid),
      .c_clr_err(c_clr_err), .c_host_down(c_host_down),
      .c_stop_out(c_stop_out), .c_end_out(c_end_out), .c_clr_in(c_clr_in),
      .c_ld_eoi(c_ld_eoi), .c_ld_out(c_ld_out), .c_ld_in(c_ld_in),
      .f_eoi(f_eoi), .f_out(f_out), .f_in(f_in),
      .err_set(err_set), .out_empty(nat_status[P_EMPTY]), .act(act),
      .ctl(ctl), .pwr(pwr), .err(err), .rdy(rdy), .eoi(eoi), .inrdy(inrdy),
      .ch_eoi(ch_eoi), .ch_out(ch_out), .ch_in(ch_in),
      .ctl_wr(ctl_wr), .clr_out(clr_out), .clr_in(clr_in),
      .clr_in_full(clr_in_full), .data_wr(data_wr));

   cstat_coni_fmt #(.WORD_W(WORD_W), .CH_W(CH_W)) i_fmt (
      .absent(absent), .node_down(node_down), .pwr(pwr), .err(err),
      .eoi(eoi), .ch_eoi(ch_eoi), .rdy(rdy), .ch_out(ch_out),
      .inrdy(inrdy), .ch_in(ch_in), .coni_word(coni_word));

   assign ctl_word  = ctl;
   assign data_word = '0;
   assign pi_req    = pi_int;

   AST_CTL_WR_AFTER_CONO: assert property (@(posedge clk) disable iff (!rst_n)
      cono_valid |=> ctl_wr); // R5
   AST_CLR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      clr_in |=> clr_in_full); // R8
   AST_DOWN_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      node_down && !absent |-> coni_word[WORD_W-1-20] && coni_word[WORD_W-1-21]); // R4
   AST_ABSENT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      nat_event && absent && !$past(ev_ok) |=> pi_req == '0); // R3
endmodule

// File: tb/test_cstat_bridge.sv
module test_cstat_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cono_valid;
   logic [35:0] cono_word;
   logic        coni_rd;
   logic [35:0] coni_word;
   logic [19:0] nat_status;
   logic        nat_event;
   logic        ctl_wr;
   logic [3:0]  ctl_word;
   logic        clr_out, clr_in, clr_in_full, data_wr;
   logic [35:0] data_word;
   logic [6:0]  pi_req;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   // model state
   bit       m_host, m_last, m_inie, m_outie;
   bit       m_err, m_rdy, m_eoi, m_inrdy;
   bit [2:0] m_che, m_cho, m_chi;

   always #(CLK_PERIOD/2) clk = ~clk;

   cstat_bridge i_cstat_bridge (
      .clk(clk), .rst_n(rst_n), .cono_valid(cono_valid), .cono_word(cono_word),
      .coni_rd(coni_rd), .coni_word(coni_word), .nat_status(nat_status),
      .nat_event(nat_event), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
      .clr_out(clr_out), .clr_in(clr_in), .clr_in_full(clr_in_full),
      .data_wr(data_wr), .data_word(data_word), .pi_req(pi_req));

   function automatic logic [6:0] oh(input bit [2:0] ch);
      return (ch == 3'd0) ? 7'd0 : 7'(7'd1 << (ch - 3'd1));
   endfunction

   function automatic logic [35:0] exp_coni(input logic [19:0] nat);
      logic [35:0] w = '0;
      if (&nat) return w;
      w[16] = 1'b1;
      w[15] = nat[19];
      w[14] = m_err | nat[19];
      w[11] = m_eoi;  w[10:8] = m_che;
      w[7]  = m_rdy;  w[6:4]  = m_cho;
      w[3]  = m_inrdy; w[2:0] = m_chi;
      return w;
   endfunction

   function automatic logic [3:0] exp_ctl();
      return {m_host, m_last, m_inie, m_outie};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_nat(input logic [19:0] v);
      @(negedge clk);
      nat_status = v;
   endtask

   task automatic do_cono(input logic [35:0] w);
      bit c19, c20, c21, c22, c23;
      @(negedge clk);
      cono_valid = 1'b1; cono_word = w;
      @(negedge clk);
      cono_valid = 1'b0; cono_word = '0;
      c19 = w[16]; c20 = w[15]; c21 = w[14]; c22 = w[13]; c23 = w[12];
      m_host = ~c20;
      if (c19) m_err = 1'b0;
      if (c22) begin m_last = 1'b1; m_rdy = 1'b0; end
      if (c21) m_outie = 1'b0;
      if (c23) begin m_inie = 1'b1; m_eoi = 1'b0; m_inrdy = 1'b0; end
      if (w[11]) begin m_che = w[10:8]; if (w[10:8] != 0) m_inie = 1'b1; end
      if (w[7])  begin m_cho = w[6:4];  if (w[6:4] != 0)  m_outie = 1'b1; end
      if (w[3])  begin m_chi = w[2:0];  if (w[2:0] != 0)  m_inie = 1'b1; end
      chk("R5 ctl_wr after cono", 64'(ctl_wr), 64'd1);
      chk("R5/R6/R9 ctl_word", 64'(ctl_word), 64'(exp_ctl()));
      chk("R6 clr_out", 64'(clr_out), 64'(c21));
      chk("R7 data_wr", 64'(data_wr), 64'(c22 & nat_status[12] & ~(&nat_status)));
      chk("R7 data_word zero", 64'(data_word), 64'd0);
      chk("R8 clr_in", 64'(clr_in), 64'(c23));
      chk("R2/R9 coni", 64'(coni_word), 64'(exp_coni(nat_status)));
      @(negedge clk);
      chk("R8 clr_in_full order", 64'({clr_in_full, clr_in}), 64'({c23, 1'b0}));
      chk("R5 ctl_wr one cycle", 64'(ctl_wr), 64'd0);
   endtask

   task automatic do_coni();
      @(negedge clk);
      coni_rd = 1'b1;
      #1;
      chk("R2 coni live", 64'(coni_word), 64'(exp_coni(nat_status)));
      @(negedge clk);
      coni_rd = 1'b0;
      if (nat_status[19] && !(&nat_status)) m_err = 1'b1;
      chk("R4 coni after read", 64'(coni_word), 64'(exp_coni(nat_status)));
   endtask

   task automatic do_event(input logic [19:0] nat);
      bit absent, fo, fi, pend, wr;
      logic [6:0] p1;
      @(negedge clk);
      nat_status = nat; nat_event = 1'b1;
      @(negedge clk);
      nat_event = 1'b0;
      absent = &nat;
      p1 = '0; pend = 0; wr = 0;
      if (!absent) begin
         fo = nat[14] & m_outie;
         fi = (nat[18] | nat[16]) & m_inie;
         if (fo) p1 |= oh(m_cho);
         if (fi) p1 |= oh(m_chi);
         if (fo) begin m_rdy = 1'b1; m_outie = 1'b0; wr = 1; end
         if (nat[18] | nat[16]) m_inrdy = 1'b1;
         if (nat[16]) m_eoi = 1'b1;
         if (fi && nat[16]) pend = 1;
         if (fi && !nat[16]) begin m_inie = 1'b0; wr = 1; end
         if (nat[19]) m_err = 1'b1;
      end
      chk("R10/R11/R12/R13 first request", 64'(pi_req), 64'(p1));
      chk("R10/R11 ctl_wr on event", 64'(ctl_wr), 64'(wr));
      chk("R10/R11/R12 ctl_word", 64'(ctl_word), 64'(exp_ctl()));
      chk("R3/R4/R10/R11/R12 coni", 64'(coni_word), 64'(exp_coni(nat_status)));
      @(negedge clk);
      if (pend) m_inie = 1'b0;
      chk("R12 second request", 64'(pi_req), 64'(pend ? oh(m_che) : 7'd0));
      chk("R12 ctl_wr second", 64'(ctl_wr), 64'(pend));
      chk("R12 enable after pair", 64'(ctl_word), 64'(exp_ctl()));
      @(negedge clk);
      chk("R13 request one cycle", 64'(pi_req), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C05));
      rst_n = 1'b0; cono_valid = 0; cono_word = '0; coni_rd = 0;
      nat_status = '0; nat_event = 0;
      m_host = 0; m_last = 0; m_inie = 0; m_outie = 0;
      m_err = 0; m_rdy = 1; m_eoi = 0; m_inrdy = 0;
      m_che = 0; m_cho = 0; m_chi = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctl_word", 64'(ctl_word), 64'd0);
      chk("R1 coni", 64'(coni_word), 64'h0_0001_0080);
      chk("R1 pi_req", 64'(pi_req), 64'd0);
      chk("R1 pulses", 64'({ctl_wr, clr_out, clr_in, clr_in_full, data_wr}), 64'd0);

      // R3 absent interface
      set_nat(20'hFFFFF);
      #1 chk("R3 coni zero", 64'(coni_word), 64'd0);
      do_coni();
      do_event(20'hFFFFF);
      set_nat(20'h0);
      #1 chk("R3 flop untouched", 64'(coni_word[14]), 64'd0);

      // R4 node down and sticky flop
      set_nat(20'h80000);
      do_coni();
      set_nat(20'h0);
      #1 chk("R4 flop held", 64'(coni_word[15:14]), 64'b01);
      do_cono(36'h0_0001_0000);  // bit 19 clears, host down clear
      chk("R4 flop cleared", 64'(coni_word[14]), 64'd0);

      // R9 channel loads: eoi 2, out 3, in 5
      do_cono(36'h0_0000_0ABD);
      chk("R9 fields", 64'(coni_word[10:0]), 64'h2B5 & 64'h7FF | 64'h000);
      // R10 needs data on channel 3
      do_event(20'h04000);
      // R12 full and last together
      do_event(20'h50000);
      // R8 clear input, then R11 full alone
      do_cono(36'h0_0000_1000);
      do_event(20'h40000);
      // R13 channel 0: load input channel 0, enable by clear input
      do_cono(36'h0_0000_1008);
      do_event(20'h40000);
      // R6 stop output and R7 end of output with empty interface
      set_nat(20'h01000);
      do_cono(36'h0_0000_6000);
      do_coni();

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom % 4);
         logic [19:0] v = 20'($urandom);
         if (($urandom % 16) != 0 && &v) v[0] = 1'b0;
         case (op)
            0: do_cono({4'h0, 32'($urandom)});
            1: do_coni();
            2: do_event(v);
            default: set_nat(v);
         endcase
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule